// File: doc/BRIEF.md
# Exhaustive Input Pattern Scanner

The block walks a binary counter through every input combination of a stateless combinational device under test. The counter value is driven straight onto the device's inputs. One device output is sampled into a register and compared against a stop level. When the registered response equals that level, the scanner freezes on the offending pattern, copies it into a match register and raises a halted flag. The held pattern can then be read back at leisure.

An operator or a supervising controller pulses `resume` to step exactly one pattern past the match. The stop condition is then armed again, so every matching combination is reported once, in ascending order. The `run_en` input gates every advance, which models a slowed or paused scan clock. The top counter bit is brought out as a slow indicator. When the counter wraps from all ones back to zero, `sweep_done` rises and scanning stays stopped until reset.

The counter is a chain of 4-bit stages. Each stage's carry enables the stage above it. The controller has four states:
- `ST_SETTLE`: the response register loads the device's answer to the current pattern.
- `ST_EVAL`: the registered response is judged. A match takes the transition to `ST_HALT`. A non-match with `run_en` high advances the counter and returns to `ST_SETTLE`, or goes to `ST_DONE` on wrap. With `run_en` low it waits in `ST_EVAL`.
- `ST_HALT`: the pattern is held. `resume` with `run_en` high advances once and goes to `ST_SETTLE`, or to `ST_DONE` on wrap.
- `ST_DONE`: terminal until reset.

Top module: `pattern_sweeper`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pattern`, `match_pattern`, `halted` and `sweep_done` are all zero.
- R2: With `run_en` held high and no match, `pattern` increases by exactly one in plain binary every second clock. A full sweep of 2^WIDTH patterns with no match sets `sweep_done` exactly 2*2^WIDTH clocks after reset release.
- R3: With the default `ACTIVE_LOW`=1, a low `dut_resp` for pattern P makes `halted` go high with `pattern` = P and `match_pattern` = P.
- R4: While `halted` is high and no resume is accepted, `pattern` and `halted` do not change, for any number of cycles.
- R5: A one-cycle `resume` pulse with `run_en` high, while halted, clears `halted` and leaves `pattern` = P+1 on the next cycle. A later match halts again.
- R6: With `run_en` low, `pattern` never advances, and a `resume` pulse while halted is ignored: `halted` stays high and `pattern` stays P.
- R7: `msb_ind` follows the top bit of `pattern`, so it rises exactly once during a full sweep.
- R8: The advance from all ones wraps `pattern` to zero and sets `sweep_done`. After that, `pattern` stays zero and `sweep_done` stays high until reset, even if `resume` is pulsed.
- R9: Over one sweep, every matching pattern is reported exactly once, in ascending order. This includes pattern zero, the all-ones pattern, and matches on adjacent patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears all counter stages |
| run_en | input | 1 | Gates every counter advance |
| resume | input | 1 | One-cycle pulse: step past the held pattern |
| dut_resp | input | 1 | Monitored output of the device under test |
| pattern | output | WIDTH | Current input pattern driven to the device |
| halted | output | 1 | Scanner is stopped on a matching pattern |
| match_pattern | output | WIDTH | Pattern captured at the most recent halt |
| msb_ind | output | 1 | Top bit of the pattern counter |
| sweep_done | output | 1 | Counter has wrapped; scanning finished |

## Verification
The assertions check the following on every clock:
- every change of `pattern` is a single binary increment;
- `run_en` low freezes the counter;
- a held pattern stays put until an accepted resume, and that resume leaves the halt state;
- `match_pattern` equals the held pattern;
- the done state is sticky at zero.

Only the bench scenarios can show the rest:
- that the halts land on exactly the combinations the device answers with the stop level, in ascending order, with none skipped;
- that the sweep takes two clocks per pattern;
- that the top-bit indicator rises once per sweep.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_EVAL   = 2'd1,
        ST_HALT   = 2'd2,
        ST_DONE   = 2'd3
    } sweep_state_t;

endpackage

// File: rtl/nibble_stage.sv
module nibble_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cin,
    output logic [W-1:0] q,
    output logic         cout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cin) begin
            q <= q + 1'b1;
        end
    end

    // carry ripples upward only when this stage is about to roll over
    assign cout = cin & (&q);

endmodule

// File: rtl/chain_counter.sv
module chain_counter #(
    parameter int WIDTH   = 8,
    parameter int STAGE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [WIDTH-1:0] count,
    output logic             wrap
);

    localparam int NST = (WIDTH + STAGE_W - 1) / STAGE_W;

    logic [NST:0] carry;

    assign carry[0] = inc;

    for (genvar i = 0; i < NST; i++) begin : g_stage
        localparam int LO = i * STAGE_W;
        localparam int SW = ((WIDTH - LO) < STAGE_W) ? (WIDTH - LO) : STAGE_W;
        logic [SW-1:0] q;

        nibble_stage #(.W(SW)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .cin  (carry[i]),
            .q    (q),
            .cout (carry[i+1])
        );

        assign count[LO +: SW] = q;
    end

    assign wrap = carry[NST];

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import sweep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic resume,
    input  logic hit,
    input  logic wrap,
    output logic advance,
    output logic capture,
    output logic halted,
    output logic done
);

    sweep_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SETTLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SETTLE: state_nx = ST_EVAL;
            ST_EVAL: begin
                if (hit) begin
                    state_nx = ST_HALT;
                end else if (run_en) begin
                    state_nx = wrap ? ST_DONE : ST_SETTLE;
                end
            end
            ST_HALT: begin
                if (resume && run_en) begin
                    state_nx = wrap ? ST_DONE : ST_SETTLE;
                end
            end
            ST_DONE: state_nx = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        advance = 1'b0;
        capture = 1'b0;
        halted  = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_SETTLE: ;
            ST_EVAL: begin
                capture = hit;
                advance = !hit && run_en;
            end
            ST_HALT: begin
                halted  = 1'b1;
                advance = resume && run_en;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/pattern_sweeper.sv
module pattern_sweeper #(
    parameter int WIDTH      = 8,
    parameter int STAGE_W    = 4,
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             resume,
    input  logic             dut_resp,
    output logic [WIDTH-1:0] pattern,
    output logic             halted,
    output logic [WIDTH-1:0] match_pattern,
    output logic             msb_ind,
    output logic             sweep_done
);

    localparam logic STOP_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;

    logic resp_q;
    logic hit;
    logic advance;
    logic capture;
    logic wrap;

    // registered device response, idle level out of reset
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= !STOP_LVL;
        end else begin
            resp_q <= dut_resp;
        end
    end

    assign hit = (resp_q == STOP_LVL);

    chain_counter #(
        .WIDTH   (WIDTH),
        .STAGE_W (STAGE_W)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .inc   (advance),
        .count (pattern),
        .wrap  (wrap)
    );

    sweep_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .resume  (resume),
        .hit     (hit),
        .wrap    (wrap),
        .advance (advance),
        .capture (capture),
        .halted  (halted),
        .done    (sweep_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_pattern <= '0;
        end else if (capture) begin
            match_pattern <= pattern;
        end
    end

    assign msb_ind = pattern[WIDTH-1];

endmodule

// File: rtl/sweep_checker.sv
module sweep_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             resume,
    input logic [WIDTH-1:0] pattern,
    input logic             halted,
    input logic [WIDTH-1:0] match_pattern,
    input logic             sweep_done
);

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(pattern)) |-> (pattern == $past(pattern) + 1'b1)); // R2

    AST_MATCH_HELD: assert property (@(posedge clk) disable iff (rst)
        halted |-> (match_pattern == pattern)); // R3

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halted && !resume) |=> (halted && $stable(pattern))); // R4

    AST_RESUME_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (halted && resume && run_en) |=> !halted); // R5

    AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(pattern)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> (sweep_done && pattern == '0)); // R8

    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(halted && sweep_done)); // R8

endmodule

bind pattern_sweeper sweep_checker #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .run_en        (run_en),
    .resume        (resume),
    .pattern       (pattern),
    .halted        (halted),
    .match_pattern (match_pattern),
    .sweep_done    (sweep_done)
);

// File: tb/pattern_sweeper_test.sv
`timescale 1ns/1ps
module pattern_sweeper_test;

    localparam int W    = 8;
    localparam int NPAT = 1 << W;
    localparam logic [W-1:0] ALL1 = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         resume = 1'b0;
    logic         dut_resp;
    logic [W-1:0] pattern;
    logic         halted;
    logic [W-1:0] match_pattern;
    logic         msb_ind;
    logic         sweep_done;

    // device model: low when masked compare hits or pattern equals extra
    logic         always_hi = 1'b1;
    logic [W-1:0] m_mask = '0;
    logic [W-1:0] m_val = '1;
    logic [W-1:0] m_extra = '0;
    assign dut_resp = always_hi | (((pattern & m_mask) != m_val) & (pattern != m_extra));

    int  checks = 0;
    int  fails = 0;
    bit  jitter = 1'b0;
    int  msb_rises = 0;
    logic msb_prev = 1'b0;

    pattern_sweeper #(.WIDTH(W)) uut (
        .clk           (clk),
        .rst           (rst),
        .run_en        (run_en),
        .resume        (resume),
        .dut_resp      (dut_resp),
        .pattern       (pattern),
        .halted        (halted),
        .match_pattern (match_pattern),
        .msb_ind       (msb_ind),
        .sweep_done    (sweep_done)
    );

    function automatic bit is_match(logic [W-1:0] p, logic hi, logic [W-1:0] mk,
                                    logic [W-1:0] vl, logic [W-1:0] ex);
        return !hi && (((p & mk) == vl) || (p == ex));
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial forever begin
        @(negedge clk);
        if (jitter) run_en = ($urandom_range(3) != 0);
    end

    initial forever begin
        @(negedge clk);
        if (!rst && msb_ind && !msb_prev) msb_rises++;
        msb_prev = msb_ind;
    end

    task automatic do_reset();
        jitter = 1'b0;
        rst    = 1'b1;
        run_en = 1'b0;
        resume = 1'b0;
        repeat (3) @(negedge clk);
        chk(pattern == 0 && match_pattern == 0, "R1", "pattern/match in reset", int'(pattern), 0);
        chk(!halted && !sweep_done, "R1", "flags in reset", int'({halted, sweep_done}), 0);
        rst    = 1'b0;
        run_en = 1'b1;
        msb_rises = 0;
    endtask

    task automatic wait_stop();
        int n = 0;
        while (!halted && !sweep_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk(1'b0, "R9", "stop not reached", n, 0);
    endtask

    task automatic resume_pulse(logic [W-1:0] p, bit jit);
        jitter = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        if (p == ALL1) begin
            chk(sweep_done && pattern == 0, "R8", "wrap after last match", int'(pattern), 0);
        end else begin
            chk(!halted && pattern == p + 1'b1, "R5", "one step past match", int'(pattern), int'(p) + 1);
        end
        jitter = jit;
    endtask

    task automatic run_scan(bit jit, bit probe_r6);
        bit first = 1'b1;
        int nm = 0;
        jitter = jit;
        for (int p = 0; p < NPAT; p++) begin
            if (is_match(W'(p), always_hi, m_mask, m_val, m_extra)) begin
                nm++;
                wait_stop();
                chk(halted && match_pattern == W'(p), "R9", "match pattern", int'(match_pattern), p);
                chk(pattern == W'(p), "R3", "held pattern", int'(pattern), p);
                if (first) begin
                    jitter = 1'b0;
                    run_en = 1'b1;
                    repeat (6) @(negedge clk);
                    chk(halted && pattern == W'(p), "R4", "hold while halted", int'(pattern), p);
                    if (probe_r6) begin
                        run_en = 1'b0;
                        resume = 1'b1;
                        @(negedge clk);
                        resume = 1'b0;
                        repeat (2) @(negedge clk);
                        chk(halted && pattern == W'(p), "R6", "resume ignored with run_en low", int'(pattern), p);
                    end
                    first = 1'b0;
                end
                resume_pulse(W'(p), jit);
            end
        end
        wait_stop();
        jitter = 1'b0;
        run_en = 1'b1;
        chk(sweep_done && !halted, "R8", "sweep done after all matches", int'(sweep_done), 1);
        chk(pattern == 0, "R8", "pattern wrapped to zero", int'(pattern), 0);
        chk(msb_rises == 1, "R7", "top bit rises once", msb_rises, 1);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        repeat (3) @(negedge clk);
        chk(sweep_done && pattern == 0, "R8", "done sticky after resume", int'(pattern), 0);
        if (nm == 0) chk(!halted, "R9", "no spurious halt", int'(halted), 0);
    endtask

    initial begin
        int n;
        logic [W-1:0] snap;
        void'($urandom(32'd20250611));

        // no match: exact sweep timing
        always_hi = 1'b1;
        do_reset();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 21) chk(pattern == W'(10), "R2", "pattern after 21 clocks", int'(pattern), 10);
        end while (!sweep_done && n < 5000);
        chk(n == 2 * NPAT, "R2", "clocks for full sweep", n, 2 * NPAT);
        chk(msb_rises == 1, "R7", "top bit rises once in clean sweep", msb_rises, 1);
        chk(pattern == 0 && !halted, "R8", "wrap to zero", int'(pattern), 0);

        // run_en freeze mid-scan
        do_reset();
        repeat (40) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        snap = pattern;
        repeat (10) @(negedge clk);
        chk(pattern == snap, "R6", "frozen with run_en low", int'(pattern), int'(snap));
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(pattern == snap + 2'd2, "R2", "resumes counting", int'(pattern), int'(snap) + 2);

        // directed: matches at 0, 1 and all ones
        always_hi = 1'b0;
        m_mask = 8'hFE;
        m_val = 8'h00;
        m_extra = 8'hFF;
        do_reset();
        run_scan(1'b0, 1'b1);

        // constrained random device functions with run_en jitter
        for (int s = 0; s < 5; s++) begin
            m_mask  = W'($urandom);
            m_val   = W'($urandom) & m_mask;
            m_extra = W'($urandom);
            if (m_mask == 0) m_mask = 8'h80;
            m_val = m_val & m_mask;
            do_reset();
            run_scan(s[0], 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule